// File: doc/BRIEF.md
# Dual-Core Mailbox Handshake Interface

A shared register block that joins two processor ports, side A and side B, through sixteen 16-bit mailbox registers. Each mailbox carries data in one direction only, set by a direction bit. A mailbox written by a side that does not own it keeps its old value. Either side may read any mailbox.

Up to eight handshake protocols can each be tied to one mailbox. That mailbox is the trigger word of a group. When the sending side writes the trigger word of an enabled protocol, the protocol's ready flag is set. The receiving side can then take an interrupt. The flag clears when the receiver reads the trigger word.

Writes to the other words of the group do not trigger anything, so software writes the trigger word last. The hardware does not block a second send while the flag is still set. Such a send overwrites the data, and a sticky overrun bit records it. Both ports are single-cycle synchronous register ports with registered read data, and both run on one shared clock.

Top module: `mbx_link`

## Requirements
- R1: A mailbox (addresses 0 to 15) written by its owning side holds the written value. It is returned to either side on a read: read data appears on the clock edge that samples the read strobe.
- R2: The direction register at address 16 holds one bit per mailbox. Bit i = 0 means side A sends on mailbox i; bit i = 1 means side B sends. A write to mailbox i by the non-sending side leaves its contents unchanged.
- R3: Protocol p is tied to a mailbox by a 4-bit index. Protocols 0 to 3 sit in the register at address 17, and protocols 4 to 7 in the register at address 18, with protocol p at bits [4(p mod 4)+3 : 4(p mod 4)]. A sender write to any mailbox other than the tied one leaves the protocol's flag unchanged.
- R4: The handshake enable register at address 19 holds one bit per protocol (bit p). While bit p is 0, writes to the tied mailbox do not set the flag.
- R5: A write by the sending side to the tied mailbox of an enabled protocol sets ready flag p. The status register at address 20 returns the ready flags in bits [7:0], with the same value on both sides.
- R6: A read of the tied mailbox by the receiving side clears ready flag p. A read of it by the sending side leaves the flag set.
- R7: Each side has its own interrupt enable register at address 21 (bit p). irq output bit p of the receiving side equals ready p AND handshake enable p AND that side's interrupt enable p. The irq output of the sending side stays 0.
- R8: A sender write to the tied mailbox while ready p is set overwrites the data, keeps the flag set and sets sticky overrun bit p (status bit 8+p). Writing 1 to status bit 8+p from either side clears it; writing 0 leaves it.
- R9: A sender trigger write and a receiver read of the same tied mailbox in one cycle return the old data to the reader, store the new data, leave the flag set and do not set overrun.
- R10: The configuration registers (addresses 16 to 19) are written only from side A. Side B writes to them are ignored.
- R11: After reset all mailboxes, configuration, flags, overrun bits and interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_we_i | input | 1 | Side A write strobe |
| a_re_i | input | 1 | Side A read strobe |
| a_addr_i | input | 5 | Side A register address |
| a_wdata_i | input | 16 | Side A write data |
| a_rdata_o | output | 16 | Side A read data, registered |
| a_irq_o | output | 8 | Side A per-protocol interrupts |
| b_we_i | input | 1 | Side B write strobe |
| b_re_i | input | 1 | Side B read strobe |
| b_addr_i | input | 5 | Side B register address |
| b_wdata_i | input | 16 | Side B write data |
| b_rdata_o | output | 16 | Side B read data, registered |
| b_irq_o | output | 8 | Side B per-protocol interrupts |

## Verification
Two events can land on the same clock edge:
- the sender writing a trigger word, which sets the ready flag;
- the receiver reading that same word, which clears it.

The bench drives both ports in one cycle on the trigger mailbox. It then checks three things:
- the reader got the data from before the write;
- a second read returns the new word;
- the status register shows the flag still set and no overrun bit.

A separate back-to-back send with no read in between is judged by the overrun bit and the overwritten data.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned N_MBX    = 16;
  localparam int unsigned N_PROTO  = 8;
  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned ADDR_DIR  = 16;
  localparam int unsigned ADDR_ATT0 = 17;
  localparam int unsigned ADDR_ATT1 = 18;
  localparam int unsigned ADDR_HSEN = 19;
  localparam int unsigned ADDR_STAT = 20;
  localparam int unsigned ADDR_IEN  = 21;
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int unsigned NumMbx = 16,
  parameter int unsigned AddrW  = 5
) (
  input  logic              we_i,
  input  logic              re_i,
  input  logic [AddrW-1:0]  addr_i,
  output logic [NumMbx-1:0] mbx_we_o,
  output logic [NumMbx-1:0] mbx_re_o
);
  for (genvar i = 0; i < NumMbx; i++) begin : g_dec
    assign mbx_we_o[i] = we_i && (addr_i == AddrW'(i));
    assign mbx_re_o[i] = re_i && (addr_i == AddrW'(i));
  end
endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int unsigned NumMbx = 16,
  parameter int unsigned DataW  = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NumMbx-1:0]            dir_i,
  input  logic [NumMbx-1:0]            a_we_i,
  input  logic [NumMbx-1:0]            b_we_i,
  input  logic [NumMbx-1:0]            a_re_i,
  input  logic [NumMbx-1:0]            b_re_i,
  input  logic [DataW-1:0]             a_wdata_i,
  input  logic [DataW-1:0]             b_wdata_i,
  output logic [NumMbx-1:0][DataW-1:0] mbx_o,
  output logic [NumMbx-1:0]            wr_ok_o,
  output logic [NumMbx-1:0]            rx_rd_o
);
  for (genvar i = 0; i < NumMbx; i++) begin : g_mbx
    logic a_ok, b_ok;
    // dir 0: A sends, B receives
    assign a_ok = a_we_i[i] && !dir_i[i];
    assign b_ok = b_we_i[i] &&  dir_i[i];
    assign wr_ok_o[i] = a_ok || b_ok;
    assign rx_rd_o[i] = (a_re_i[i] && dir_i[i]) || (b_re_i[i] && !dir_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mbx_o[i] <= '0;
      else if (a_ok) mbx_o[i] <= a_wdata_i;
      else if (b_ok) mbx_o[i] <= b_wdata_i;
    end

    a_r2_owner_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_we_i[i] && !dir_i[i] && !a_we_i[i]) |=> $stable(mbx_o[i]));
    a_r2_owner_only_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_we_i[i] && dir_i[i] && !b_we_i[i]) |=> $stable(mbx_o[i]));
    a_r1_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_we_i[i] && !dir_i[i]) |=> (mbx_o[i] == $past(a_wdata_i)));
  end
endmodule

// File: rtl/mbx_proto_ctl.sv
module mbx_proto_ctl #(
  parameter int unsigned NumMbx = 16,
  parameter int unsigned IdxW   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [IdxW-1:0]   idx_i,
  input  logic [NumMbx-1:0] wr_ok_i,
  input  logic [NumMbx-1:0] rx_rd_i,
  input  logic              ovr_clr_i,
  output logic              ready_o,
  output logic              ovr_o
);
  logic trig, clr;
  assign trig = en_i && wr_ok_i[idx_i];
  assign clr  = en_i && rx_rd_i[idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_o <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      // set wins over clear in the same cycle
      if (trig)     ready_o <= 1'b1;
      else if (clr) ready_o <= 1'b0;
      if (trig && ready_o && !clr) ovr_o <= 1'b1;
      else if (ovr_clr_i)          ovr_o <= 1'b0;
    end
  end

  a_r5_trig_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> ready_o);
  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !trig) |=> !ready_o);
  a_r4_disabled_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ready_o));
  a_r8_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && ready_o && !clr) |=> (ovr_o && ready_o));
  a_r9_same_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig && clr && !ovr_o && !ovr_clr_i) |=> (ready_o && !ovr_o));
endmodule

// File: rtl/mbx_link.sv
module mbx_link
  import mbx_pkg::*;
#(
  parameter int unsigned DataW   = DATA_W,
  parameter int unsigned NumMbx  = N_MBX,
  parameter int unsigned NumProto = N_PROTO,
  parameter int unsigned AddrW   = ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                a_we_i,
  input  logic                a_re_i,
  input  logic [AddrW-1:0]    a_addr_i,
  input  logic [DataW-1:0]    a_wdata_i,
  output logic [DataW-1:0]    a_rdata_o,
  output logic [NumProto-1:0] a_irq_o,
  input  logic                b_we_i,
  input  logic                b_re_i,
  input  logic [AddrW-1:0]    b_addr_i,
  input  logic [DataW-1:0]    b_wdata_i,
  output logic [DataW-1:0]    b_rdata_o,
  output logic [NumProto-1:0] b_irq_o
);
  localparam int unsigned IdxW = $clog2(NumMbx);
  localparam int unsigned AttW = 2 * DataW;

  logic [NumMbx-1:0]            a_mwe, a_mre, b_mwe, b_mre, wr_ok, rx_rd;
  logic [NumMbx-1:0][DataW-1:0] mbx;
  logic [NumMbx-1:0]            dir_q;
  logic [AttW-1:0]              att_q;
  logic [NumProto-1:0]          hsen_q, ien_a_q, ien_b_q, rdy, ovr, ovr_clr;
  logic [DataW-1:0]             a_rd_nxt, b_rd_nxt;

  mbx_port_dec #(.NumMbx(NumMbx), .AddrW(AddrW)) i_dec_a (
    .we_i(a_we_i), .re_i(a_re_i), .addr_i(a_addr_i),
    .mbx_we_o(a_mwe), .mbx_re_o(a_mre));
  mbx_port_dec #(.NumMbx(NumMbx), .AddrW(AddrW)) i_dec_b (
    .we_i(b_we_i), .re_i(b_re_i), .addr_i(b_addr_i),
    .mbx_we_o(b_mwe), .mbx_re_o(b_mre));

  mbx_store #(.NumMbx(NumMbx), .DataW(DataW)) i_store (
    .clk_i, .rst_ni, .dir_i(dir_q),
    .a_we_i(a_mwe), .b_we_i(b_mwe), .a_re_i(a_mre), .b_re_i(b_mre),
    .a_wdata_i, .b_wdata_i, .mbx_o(mbx), .wr_ok_o(wr_ok), .rx_rd_o(rx_rd));

  // configuration, side A only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      att_q  <= '0;
      hsen_q <= '0;
    end else if (a_we_i) begin
      if (a_addr_i == AddrW'(ADDR_DIR))  dir_q  <= a_wdata_i[NumMbx-1:0];
      if (a_addr_i == AddrW'(ADDR_ATT0)) att_q[DataW-1:0] <= a_wdata_i;
      if (a_addr_i == AddrW'(ADDR_ATT1)) att_q[AttW-1:DataW] <= a_wdata_i;
      if (a_addr_i == AddrW'(ADDR_HSEN)) hsen_q <= a_wdata_i[NumProto-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_a_q <= '0;
      ien_b_q <= '0;
    end else begin
      if (a_we_i && a_addr_i == AddrW'(ADDR_IEN)) ien_a_q <= a_wdata_i[NumProto-1:0];
      if (b_we_i && b_addr_i == AddrW'(ADDR_IEN)) ien_b_q <= b_wdata_i[NumProto-1:0];
    end
  end

  // overrun write-one-to-clear from either side
  always_comb begin
    ovr_clr = '0;
    if (a_we_i && a_addr_i == AddrW'(ADDR_STAT)) ovr_clr |= a_wdata_i[NumProto +: NumProto];
    if (b_we_i && b_addr_i == AddrW'(ADDR_STAT)) ovr_clr |= b_wdata_i[NumProto +: NumProto];
  end

  for (genvar p = 0; p < NumProto; p++) begin : g_proto
    logic [IdxW-1:0] idx;
    assign idx = att_q[p*IdxW +: IdxW];

    mbx_proto_ctl #(.NumMbx(NumMbx), .IdxW(IdxW)) i_proto (
      .clk_i, .rst_ni, .en_i(hsen_q[p]), .idx_i(idx),
      .wr_ok_i(wr_ok), .rx_rd_i(rx_rd), .ovr_clr_i(ovr_clr[p]),
      .ready_o(rdy[p]), .ovr_o(ovr[p]));

    // receiver is A when the tied mailbox flows B to A
    assign a_irq_o[p] = rdy[p] && hsen_q[p] && ien_a_q[p] &&  dir_q[idx];
    assign b_irq_o[p] = rdy[p] && hsen_q[p] && ien_b_q[p] && !dir_q[idx];
  end

  function automatic logic [DataW-1:0] rd_mux(input logic [AddrW-1:0] addr,
                                              input logic [NumProto-1:0] ien);
    logic [DataW-1:0] r;
    r = '0;
    if (addr < AddrW'(NumMbx)) r = mbx[addr[IdxW-1:0]];
    else if (addr == AddrW'(ADDR_DIR))  r = DataW'(dir_q);
    else if (addr == AddrW'(ADDR_ATT0)) r = att_q[DataW-1:0];
    else if (addr == AddrW'(ADDR_ATT1)) r = att_q[AttW-1:DataW];
    else if (addr == AddrW'(ADDR_HSEN)) r = DataW'(hsen_q);
    else if (addr == AddrW'(ADDR_STAT)) r = DataW'({ovr, rdy});
    else if (addr == AddrW'(ADDR_IEN))  r = DataW'(ien);
    return r;
  endfunction

  assign a_rd_nxt = rd_mux(a_addr_i, ien_a_q);
  assign b_rd_nxt = rd_mux(b_addr_i, ien_b_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_re_i) a_rdata_o <= a_rd_nxt;
      if (b_re_i) b_rdata_o <= b_rd_nxt;
    end
  end

  a_r7_irq_one_side: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_irq_o & b_irq_o) == '0);
  a_r10_b_cfg_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_we_i && !a_we_i && b_addr_i == AddrW'(ADDR_DIR)) |=> $stable(dir_q));
  a_r5_status_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_re_i && b_re_i && a_addr_i == AddrW'(ADDR_STAT) && b_addr_i == AddrW'(ADDR_STAT))
      |=> (a_rdata_o == b_rdata_o));
endmodule

// File: tb/test_mbx_link.sv
`timescale 1ns/1ps
module test_mbx_link;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_we_i = 0, a_re_i = 0, b_we_i = 0, b_re_i = 0;
  logic [4:0]  a_addr_i = '0, b_addr_i = '0;
  logic [15:0] a_wdata_i = '0, b_wdata_i = '0;
  logic [15:0] a_rdata_o, b_rdata_o;
  logic [7:0]  a_irq_o, b_irq_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  mbx_link i_mbx_link (.*);

  typedef struct packed {
    logic        side;  // 0 = A, 1 = B
    logic        wr;
    logic [4:0]  addr;
    logic [15:0] data;  // write data or expected read data
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 5'd16, 16'hFF00, 4'd2},  // dir: 8..15 flow B to A
    '{1'b0, 1'b1, 5'd17, 16'h00F7, 4'd3},  // proto0 -> mbx7, proto1 -> mbx15
    '{1'b0, 1'b1, 5'd19, 16'h0003, 4'd4},  // enable proto 0,1
    '{1'b0, 1'b1, 5'd3,  16'h1234, 4'd1},  // R1
    '{1'b1, 1'b0, 5'd3,  16'h1234, 4'd1},
    '{1'b1, 1'b1, 5'd3,  16'hDEAD, 4'd2},  // R2 non-owner write
    '{1'b0, 1'b0, 5'd3,  16'h1234, 4'd2},
    '{1'b0, 1'b1, 5'd7,  16'h5555, 4'd5},  // R5 trigger
    '{1'b1, 1'b0, 5'd20, 16'h0001, 4'd5},
    '{1'b0, 1'b0, 5'd20, 16'h0001, 4'd5},
    '{1'b0, 1'b0, 5'd7,  16'h5555, 4'd6},  // R6 sender read
    '{1'b1, 1'b0, 5'd20, 16'h0001, 4'd6},
    '{1'b1, 1'b0, 5'd7,  16'h5555, 4'd6},  // receiver read
    '{1'b1, 1'b0, 5'd20, 16'h0000, 4'd6},
    '{1'b1, 1'b1, 5'd8,  16'h0042, 4'd3},  // R3 non-tied word
    '{1'b0, 1'b0, 5'd20, 16'h0000, 4'd3},
    '{1'b1, 1'b1, 5'd15, 16'h0099, 4'd5},  // B sends on proto1
    '{1'b1, 1'b0, 5'd20, 16'h0002, 4'd5},
    '{1'b0, 1'b0, 5'd15, 16'h0099, 4'd6},
    '{1'b0, 1'b0, 5'd20, 16'h0000, 4'd6},
    '{1'b1, 1'b1, 5'd16, 16'h0000, 4'd10}, // R10 B cfg write
    '{1'b0, 1'b0, 5'd16, 16'hFF00, 4'd10}
  };

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [4:0] ad, input logic [15:0] d);
    @(negedge clk_i);
    if (s) begin b_we_i = 1; b_addr_i = ad; b_wdata_i = d; end
    else   begin a_we_i = 1; a_addr_i = ad; a_wdata_i = d; end
    @(negedge clk_i);
    a_we_i = 0; b_we_i = 0;
  endtask

  task automatic rd(input logic s, input logic [4:0] ad, output logic [15:0] q);
    @(negedge clk_i);
    if (s) begin b_re_i = 1; b_addr_i = ad; end
    else   begin a_re_i = 1; a_addr_i = ad; end
    @(negedge clk_i);
    a_re_i = 0; b_re_i = 0;
    q = s ? b_rdata_o : a_rdata_o;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q;
    repeat (3) @(negedge clk_i);
    chk(11, {8'h0, a_irq_o | b_irq_o}, 16'h0);  // R11 during reset
    rst_ni = 1;
    rd(1'b0, 5'd20, q); chk(11, q, 16'h0);      // R11
    rd(1'b1, 5'd16, q); chk(11, q, 16'h0);
    rd(1'b0, 5'd7,  q); chk(11, q, 16'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].side, VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].side, VEC[i].addr, q);
        chk(int'(VEC[i].req), q, VEC[i].data);
      end
    end

    // R4: disabled protocol ignores trigger
    wr(1'b0, 5'd19, 16'h0002);
    wr(1'b0, 5'd7, 16'h0707);
    rd(1'b1, 5'd20, q); chk(4, q, 16'h0000);
    wr(1'b0, 5'd19, 16'h0003);
    rd(1'b1, 5'd20, q); chk(4, q, 16'h0000);

    // R7: receiver interrupt level
    wr(1'b1, 5'd21, 16'h0001);
    wr(1'b0, 5'd21, 16'h0001);
    chk(7, {8'h0, b_irq_o}, 16'h0000);
    wr(1'b0, 5'd7, 16'h7777);
    chk(7, {8'h0, b_irq_o}, 16'h0001);
    chk(7, {8'h0, a_irq_o}, 16'h0000);
    rd(1'b1, 5'd21, q); chk(7, q, 16'h0001);
    rd(1'b1, 5'd7, q);  chk(7, q, 16'h7777);
    chk(7, {8'h0, b_irq_o}, 16'h0000);

    // R8: overrun
    wr(1'b0, 5'd7, 16'h1111);
    wr(1'b0, 5'd7, 16'h2222);
    rd(1'b0, 5'd20, q); chk(8, q, 16'h0101);
    rd(1'b1, 5'd7, q);  chk(8, q, 16'h2222);
    rd(1'b1, 5'd20, q); chk(8, q, 16'h0100);
    wr(1'b1, 5'd20, 16'h00FF);
    rd(1'b0, 5'd20, q); chk(8, q, 16'h0100);
    wr(1'b1, 5'd20, 16'h0100);
    rd(1'b0, 5'd20, q); chk(8, q, 16'h0000);

    // R9: trigger write and receiver read in one cycle
    wr(1'b0, 5'd7, 16'hAAAA);
    @(negedge clk_i);
    a_we_i = 1; a_addr_i = 5'd7; a_wdata_i = 16'hBBBB;
    b_re_i = 1; b_addr_i = 5'd7;
    @(negedge clk_i);
    a_we_i = 0; b_re_i = 0;
    chk(9, b_rdata_o, 16'hAAAA);
    rd(1'b0, 5'd20, q); chk(9, q, 16'h0001);
    rd(1'b1, 5'd7, q);  chk(9, q, 16'hBBBB);
    rd(1'b1, 5'd20, q); chk(9, q, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule